// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the combinational arithmetic-logic stage of a 32-bit integer datapath. It takes a first source operand, a second source operand that an upstream shifter has already prepared, and a 4-bit operation code. From these it produces the operation's value, a result write-enable, and the next value of the four condition flags: negative (N), zero (Z), carry (C) and overflow (V).

The incoming flag word supplies the carry for the carry-chained operations. It also supplies the overflow bit that the logical operations keep. The shifter's carry-out enters on its own pin and becomes the carry flag of the logical operations. Four of the sixteen codes only compare or test. They always refresh the flags and never request a register write. The other twelve refresh the flags only when the set-flags input is high. When the flags are not refreshed, the block passes the incoming flag word through unchanged, so the caller can store its output flags on every cycle.

Top module: `dp_alu`

## Requirements
- R1: Code 4 gives A+B on the result. Code 5 gives A+B+Cin, where Cin is bit 1 of the incoming flags.
- R2: Code 2 gives A−B. Code 6 gives A−B+Cin−1.
- R3: Code 3 gives B−A. Code 7 gives B−A+Cin−1.
- R4: The result is A AND B for code 0, A XOR B for code 1, A OR B for code 12, and A AND NOT B for code 14.
- R5: Code 13 passes B to the result and code 15 gives NOT B. For both codes the value of A has no effect on any output.
- R6: Codes 8 to 11 set the result to A AND B (8), A XOR B (9), A−B (10) or A+B (11), and hold the write-enable low. All other codes drive the write-enable high.
- R7: When the flags are refreshed, flag N (bit 3) equals result bit 31, and flag Z (bit 2) is set exactly when the 32-bit result is zero.
- R8: For codes 2 to 7, 10 and 11, a refreshed carry flag (bit 1) is the adder carry-out, which reads 1 on a subtraction that needs no borrow. A refreshed overflow flag (bit 0) is set exactly when the signed result is out of range.
- R9: For codes 0, 1, 8, 9 and 12 to 15, a refreshed carry flag equals the shifter carry-out input, and the overflow flag keeps its incoming value.
- R10: The flags are refreshed, and the update output is high, when the set-flags input is high or the code is 8 to 11. Otherwise the flag output equals the incoming flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First source operand |
| b_i | input | 32 | Second source operand, already shifted |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Request a flag update for non-compare codes |
| nzcv_i | input | 4 | Current flags {N,Z,C,V} |
| shift_c_i | input | 1 | Carry-out of the operand shifter |
| res_o | output | 32 | Operation value |
| wr_en_o | output | 1 | Result should be written to the destination |
| nzcv_o | output | 4 | Next flags {N,Z,C,V} |
| flag_upd_o | output | 1 | Flags were refreshed by this operation |

## Verification
The block holds no state, so any fault in operand routing, carry injection or the flag mux appears at the ports in the same cycle that the inputs are applied. A swapped operand in the reverse subtracts, or a wrong carry constant, alters the result or the carry of a single code. The bench therefore covers every code with operand pairs that reach the carry and signed-overflow boundaries, and with both incoming carry values. A wrong update decision appears as flags that change when they should have held, so these cases are checked with incoming flags that differ from the refreshed ones.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;

  // compare/test group: codes 8..11
  function automatic logic is_test(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic is_arith(input logic [3:0] op);
    return (op[3:2] == 2'b01) || (op[3:1] == 3'b001) || (op[3:1] == 3'b101);
  endfunction

endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
  import dp_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_op_e          op_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             ci;
  logic [WIDTH:0]   wide;

  // subtraction as x + ~y + ci; ci=1 for plain, flag carry for chained
  always_comb begin
    x  = a_i;
    y  = b_i;
    ci = 1'b0;
    unique case (op_i)
      OP_ADD, OP_CMN: ci = 1'b0;
      OP_ADC:         ci = cin_i;
      OP_SUB, OP_CMP: begin y = ~b_i; ci = 1'b1;  end
      OP_SBC:         begin y = ~b_i; ci = cin_i; end
      OP_RSB:         begin x = b_i; y = ~a_i; ci = 1'b1;  end
      OP_RSC:         begin x = b_i; y = ~a_i; ci = cin_i; end
      default:        ci = 1'b0;
    endcase
  end

  assign wide   = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  assign sum_o  = wide[MSB:0];
  assign cout_o = wide[WIDTH];
  assign ovf_o  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_op_e          op_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MOV:         res_o = b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic             arith_i,
  input  logic             upd_i,
  input  logic             add_c_i,
  input  logic             add_v_i,
  input  logic             shift_c_i,
  input  logic [3:0]       nzcv_i,
  output logic [3:0]       nzcv_o
);
  logic [3:0] fresh;

  always_comb begin
    fresh[FLAG_N] = res_i[WIDTH-1];
    fresh[FLAG_Z] = ~|res_i;
    fresh[FLAG_C] = arith_i ? add_c_i : shift_c_i;
    fresh[FLAG_V] = arith_i ? add_v_i : nzcv_i[FLAG_V];
  end

  assign nzcv_o = upd_i ? fresh : nzcv_i;

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       op_i,
  input  logic             set_flags_i,
  input  logic [3:0]       nzcv_i,
  input  logic             shift_c_i,
  output logic [WIDTH-1:0] res_o,
  output logic             wr_en_o,
  output logic [3:0]       nzcv_o,
  output logic             flag_upd_o
);
  alu_op_e          op;
  logic             arith, test;
  logic [WIDTH-1:0] sum, lres;
  logic             add_c, add_v;

  assign op    = alu_op_e'(op_i);
  assign arith = is_arith(op_i);
  assign test  = is_test(op_i);

  dp_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (op),
    .cin_i (nzcv_i[FLAG_C]),
    .sum_o (sum),
    .cout_o(add_c),
    .ovf_o (add_v)
  );

  dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (op),
    .res_o(lres)
  );

  assign res_o      = arith ? sum : lres;
  assign wr_en_o    = ~test;
  assign flag_upd_o = set_flags_i | test;

  dp_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .res_i    (res_o),
    .arith_i  (arith),
    .upd_i    (flag_upd_o),
    .add_c_i  (add_c),
    .add_v_i  (add_v),
    .shift_c_i(shift_c_i),
    .nzcv_i   (nzcv_i),
    .nzcv_o   (nzcv_o)
  );

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       op_i,
  input logic             set_flags_i,
  input logic [3:0]       nzcv_i,
  input logic             shift_c_i,
  input logic [WIDTH-1:0] res_o,
  input logic             wr_en_o,
  input logic [3:0]       nzcv_o,
  input logic             flag_upd_o
);
  logic logical;
  assign logical = (op_i[3:2] == 2'b11) || (op_i[3:1] == 3'b000) || (op_i[3:1] == 3'b100);

  always_comb begin
    // R6
    no_write_on_test_chk: assert (!(op_i[3:2] == 2'b10) || !wr_en_o)
      else $error("write-enable high on compare/test code");
    // R10
    test_updates_chk: assert (!(op_i[3:2] == 2'b10) || flag_upd_o)
      else $error("compare/test code did not refresh flags");
    // R10
    hold_flags_chk: assert (flag_upd_o || (nzcv_o == nzcv_i))
      else $error("flags changed without update");
    // R5
    mov_pass_chk: assert (op_i != 4'hD || res_o == b_i)
      else $error("move did not pass B");
    // R9
    logic_v_keep_chk: assert (!(flag_upd_o && logical) ||
                              (nzcv_o[0] == nzcv_i[0] && nzcv_o[1] == shift_c_i))
      else $error("logical op carry/overflow wrong");
    // R7
    n_bit_chk: assert (!flag_upd_o || nzcv_o[3] == res_o[WIDTH-1])
      else $error("N flag does not follow result sign");
  end
endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .op_i       (op_i),
  .set_flags_i(set_flags_i),
  .nzcv_i     (nzcv_i),
  .shift_c_i  (shift_c_i),
  .res_o      (res_o),
  .wr_en_o    (wr_en_o),
  .nzcv_o     (nzcv_o),
  .flag_upd_o (flag_upd_o)
);

// File: tb/sim_dp_alu.sv
`timescale 1ns/1ps
module sim_dp_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b;
  logic [3:0]  op;
  logic        sf;
  logic [3:0]  fin;
  logic        shc;
  logic [31:0] res;
  logic        we;
  logic [3:0]  fout;
  logic        upd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [3:0]  nzcv;
    logic        upd;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  dp_alu u0 (
    .a_i(a), .b_i(b), .op_i(op), .set_flags_i(sf), .nzcv_i(fin),
    .shift_c_i(shc), .res_o(res), .wr_en_o(we), .nzcv_o(fout), .flag_upd_o(upd)
  );

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'h4, 4'h5: return "R1";
      4'h2, 4'h6: return "R2";
      4'h3, 4'h7: return "R3";
      4'h0, 4'h1, 4'hC, 4'hE: return "R4";
      4'hD, 4'hF: return "R5";
      default: return "R6";
    endcase
  endfunction

  // expected values from the requirement text, signed range check in 64 bits
  function automatic exp_t model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                                 input logic s, input logic [3:0] f, input logic sc);
    exp_t e;
    longint sx, sy, sr;
    longint unsigned ux, uy, ur;
    logic ci, ar, c, v;
    sx = longint'($signed(x)); sy = longint'($signed(y));
    ux = {32'd0, x}; uy = {32'd0, y};
    ci = f[1];
    ar = 1'b1; c = 1'b0; sr = 0; ur = 0;
    case (o)
      4'h4, 4'hB: begin ur = ux + uy;      sr = sx + sy;      end
      4'h5:       begin ur = ux + uy + ci; sr = sx + sy + ci; end
      4'h2, 4'hA: begin ur = ux - uy;      sr = sx - sy;      end
      4'h6:       begin ur = ux - uy - (1 - ci); sr = sx - sy - (1 - ci); end
      4'h3:       begin ur = uy - ux;      sr = sy - sx;      end
      4'h7:       begin ur = uy - ux - (1 - ci); sr = sy - sx - (1 - ci); end
      default:    ar = 1'b0;
    endcase
    if (ar) begin
      e.res = ur[31:0];
      if (o inside {4'h4, 4'h5, 4'hB}) c = (ur > 64'hFFFF_FFFF);
      else c = ~ur[63]; // no borrow when non-negative
      v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    end else begin
      case (o)
        4'h0, 4'h8: e.res = x & y;
        4'h1, 4'h9: e.res = x ^ y;
        4'hC:       e.res = x | y;
        4'hE:       e.res = x & ~y;
        4'hD:       e.res = y;
        default:    e.res = ~y;
      endcase
      c = sc;
      v = f[0];
    end
    e.we  = !(o >= 4'h8 && o <= 4'hB);
    e.upd = s || !e.we;
    e.nzcv = e.upd ? {e.res[31], (e.res == 32'd0), c, v} : f;
    e.tag = tag_of(o);
    return e;
  endfunction

  task automatic drive(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic s, input logic [3:0] f, input logic sc, input string t);
    exp_t e;
    @(posedge clk);
    op = o; a = x; b = y; sf = s; fin = f; shc = sc;
    e = model(o, x, y, s, f, sc);
    if (t != "") e.tag = t;
    sb.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (res !== e.res || we !== e.we || fout !== e.nzcv || upd !== e.upd) begin
        fails++;
        $display("FAIL %s op=%h: res=%h we=%b nzcv=%b upd=%b exp res=%h we=%b nzcv=%b upd=%b",
                 e.tag, op, res, we, fout, upd, e.res, e.we, e.nzcv, e.upd);
      end
    end
  end

  initial begin
    a = '0; b = '0; op = '0; sf = 1'b0; fin = '0; shc = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle state: AND of zeros writes zero, flags held
    drive(4'h0, 0, 0, 1'b0, 4'b0000, 1'b0, "R4");
    // R1 carry out to zero, and signed overflow
    drive(4'h4, 32'hFFFF_FFFF, 32'h1, 1'b1, 4'b0000, 1'b0, "R1");
    drive(4'h4, 32'h7FFF_FFFF, 32'h1, 1'b1, 4'b0000, 1'b0, "R8");
    drive(4'h5, 32'h10, 32'h20, 1'b1, 4'b0010, 1'b0, "R1");
    drive(4'h5, 32'h10, 32'h20, 1'b1, 4'b0000, 1'b0, "R1");
    // R2 equal, borrow, SBC with both carries
    drive(4'h2, 32'h55, 32'h55, 1'b1, 4'b0000, 1'b0, "R7");
    drive(4'h2, 32'h0, 32'h1, 1'b1, 4'b0000, 1'b0, "R8");
    drive(4'h2, 32'h8000_0000, 32'h1, 1'b1, 4'b0000, 1'b0, "R8");
    drive(4'h6, 32'h100, 32'h1, 1'b1, 4'b0000, 1'b0, "R2");
    drive(4'h6, 32'h100, 32'h1, 1'b1, 4'b0010, 1'b0, "R2");
    // R3
    drive(4'h3, 32'h5, 32'h9, 1'b1, 4'b0000, 1'b0, "R3");
    drive(4'h7, 32'h5, 32'h9, 1'b1, 4'b0000, 1'b0, "R3");
    drive(4'h7, 32'h9, 32'h9, 1'b1, 4'b0010, 1'b0, "R3");
    // R4 / R9
    drive(4'hE, 32'hF0F0_FFFF, 32'h0000_FF00, 1'b1, 4'b0001, 1'b1, "R9");
    drive(4'hC, 32'h8000_0000, 32'h1, 1'b1, 4'b0000, 1'b0, "R4");
    drive(4'h1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1, 4'b1011, 1'b0, "R9");
    // R5: A must not matter
    drive(4'hD, 32'h1234_5678, 32'hCAFE_0001, 1'b1, 4'b0000, 1'b1, "R5");
    drive(4'hD, 32'hFFFF_FFFF, 32'hCAFE_0001, 1'b1, 4'b0000, 1'b1, "R5");
    drive(4'hF, 32'h0, 32'hFFFF_FFFF, 1'b1, 4'b0001, 1'b0, "R5");
    drive(4'hF, 32'h1357_9BDF, 32'hFFFF_FFFF, 1'b1, 4'b0001, 1'b0, "R5");
    // R6 compare/test with s low still update
    drive(4'hA, 32'h3, 32'h3, 1'b0, 4'b1001, 1'b0, "R6");
    drive(4'hB, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'b0000, 1'b0, "R6");
    drive(4'h8, 32'hF0, 32'h0F, 1'b0, 4'b0001, 1'b1, "R6");
    drive(4'h9, 32'h8000_0000, 32'h0, 1'b0, 4'b0000, 1'b0, "R6");
    // R10 hold with s low
    drive(4'h4, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'b1010, 1'b0, "R10");
    drive(4'hD, 32'h0, 32'h0, 1'b0, 4'b0101, 1'b1, "R10");
    // sweep all codes
    for (int i = 0; i < 320; i++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom;
      if (i % 5 == 0) y = x;
      if (i % 7 == 0) x = 32'h7FFF_FFFF;
      drive(4'(i % 16), x, y, 1'(i / 16 % 2), 4'($urandom), 1'($urandom), "");
    end
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule